// File: doc/BRIEF.md
# Two-Slot Re-Reading Message Buffer

This block passes data items from a writer that can afford to wait to a reader that must never wait. It holds two data slots and three single-bit control flags: a writer slot pointer, a reader slot pointer and a read guard. The reader may ask for data at any time and always gets an answer after a fixed number of cycles. If no new item has arrived since its last access, it gets the newest completed item again. The writer is held off until the reader has picked up the item it wrote last, and also while a read access is in progress. Because of this, no written item is ever overwritten before the reader has seen it.

Both sides run in one clock domain but use multi-cycle access phases, so read and write accesses overlap in time. The pointer protocol keeps every overlapping pair of accesses on different slots. The writer holds `wr_req` and `wr_data` steady until `wr_done` pulses, and `wr_stall` shows when it is being held off. The reader pulses `rd_req` while idle and receives `rd_data` together with a one-cycle `rd_valid`.

The writer machine has four states and these transitions:
- W_IDLE: a request goes to W_WRITE when the path is clear, and to W_HOLD when it is not.
- W_HOLD: goes to W_WRITE once the path clears.
- W_WRITE: runs for WR_CYC cycles and commits the slot on its last cycle, then goes to W_FLIP.
- W_FLIP: toggles the writer pointer, pulses done and returns to W_IDLE.

The reader machine has five states and these transitions:
- R_IDLE: a request moves it to R_SEL.
- R_SEL: points the reader at the slot written last, then goes to R_GUARD.
- R_GUARD: raises the guard, then goes to R_READ.
- R_READ: runs for RD_CYC cycles and captures the slot on its last cycle, then goes to R_DONE.
- R_DONE: lowers the guard, presents the data and returns to R_IDLE.

Top module: `msg_buf2`

## Requirements
- R1: After reset both slots hold zero, the writer pointer is 1 and the reader pointer is 0. `wr_done`, `wr_stall` and `rd_valid` are low. The first write is not held off, and a read before any write returns zero.
- R2: A read request accepted while the reader is idle produces `rd_valid` for exactly one cycle, RD_CYC+3 clock edges after the accepting edge, whatever the writer is doing.
- R3: A read that overlaps no write returns the newest completed item. Repeated reads with no write in between return that same item again.
- R4: A write starts only when the writer pointer differs from the reader pointer. After a completed write, the next write is held off until a read has selected that item, so no item is lost.
- R5: A write cannot start on an edge where the read guard is high. A request made during the read phase starts on the edge after the guard falls.
- R6: An unblocked write request produces `wr_done` for exactly one cycle, WR_CYC+1 clock edges after the accepting edge.
- R7: Items are returned in the order they were written. A read never returns an item older than the one returned by the previous read.
- R8: The writer never writes the slot that an active read (guard high) is reading.
- R9: `wr_stall` is high on every cycle a pending request is held off, and never together with `wr_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_req | input | 1 | Write request, held with data until done |
| wr_data | input | DATA_W | Item to write |
| wr_done | output | 1 | One-cycle pulse: item committed |
| wr_stall | output | 1 | Pending write is being held off |
| rd_req | input | 1 | Read request, taken when the reader is idle |
| rd_valid | output | 1 | One-cycle pulse: `rd_data` holds the result |
| rd_data | output | DATA_W | Item returned by the read |

## Verification
A wrong pointer or guard value shows up at the ports in one of three ways. A stale pointer makes a read return an item older than a previous one, or skip an item, within one read of the fault. A wrong hold decision shows as `wr_done` arriving while the reader has not yet consumed the earlier item. A missed guard shows as a write finishing earlier than the cycle worked out from the read timing. Each returned value is matched against the list of written items, so a torn or unknown value is caught on the `rd_valid` cycle where it appears.

// File: rtl/msg_buf2_pkg.sv
package msg_buf2_pkg;

    typedef enum logic [1:0] {
        W_IDLE,
        W_HOLD,
        W_WRITE,
        W_FLIP
    } wr_state_e;

    typedef enum logic [2:0] {
        R_IDLE,
        R_SEL,
        R_GUARD,
        R_READ,
        R_DONE
    } rd_state_e;

endpackage

// File: rtl/msg_buf2_wr_fsm.sv
module msg_buf2_wr_fsm
    import msg_buf2_pkg::*;
#(
    parameter int WR_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_req,
    input  logic r_ptr,
    input  logic guard,
    output logic w_ptr,
    output logic slot_we,
    output logic wr_active,
    output logic wr_done,
    output logic wr_stall
);
    localparam int CW = (WR_CYC > 1) ? $clog2(WR_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(WR_CYC - 1);

    wr_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic w_q;
    logic path_clear;

    // The writer may only enter a slot the reader has moved away from,
    // and never while a read is under way.
    assign path_clear = (w_q != r_ptr) && !guard;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            W_IDLE:  if (wr_req) state_d = path_clear ? W_WRITE : W_HOLD;
            W_HOLD:  if (path_clear) state_d = W_WRITE;
            W_WRITE: if (cnt_q == LAST) state_d = W_FLIP;
            W_FLIP:  state_d = W_IDLE;
            default: state_d = W_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= W_IDLE;
            cnt_q   <= '0;
            w_q     <= 1'b1;
        end else begin
            state_q <= state_d;
            if (state_q == W_WRITE && state_d == W_WRITE)
                cnt_q <= cnt_q + 1'b1;
            else
                cnt_q <= '0;
            if (state_q == W_FLIP)
                w_q <= ~w_q;
        end
    end

    always_comb begin
        slot_we   = 1'b0;
        wr_active = 1'b0;
        wr_done   = 1'b0;
        wr_stall  = 1'b0;
        unique case (state_q)
            W_IDLE:  wr_stall = wr_req && !path_clear;
            W_HOLD:  wr_stall = 1'b1;
            W_WRITE: begin
                wr_active = 1'b1;
                slot_we   = (cnt_q == LAST);
            end
            W_FLIP:  wr_done = 1'b1;
            default: ;
        endcase
    end

    assign w_ptr = w_q;

endmodule

// File: rtl/msg_buf2_rd_fsm.sv
module msg_buf2_rd_fsm
    import msg_buf2_pkg::*;
#(
    parameter int RD_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_req,
    input  logic w_ptr,
    output logic r_ptr,
    output logic guard,
    output logic capture,
    output logic rd_valid
);
    localparam int CW = (RD_CYC > 1) ? $clog2(RD_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(RD_CYC - 1);

    rd_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic r_q;
    logic g_q;

    // The reader never consults the writer's progress when deciding
    // whether to proceed: its path through the states is fixed.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            R_IDLE:  if (rd_req) state_d = R_SEL;
            R_SEL:   state_d = R_GUARD;
            R_GUARD: state_d = R_READ;
            R_READ:  if (cnt_q == LAST) state_d = R_DONE;
            R_DONE:  state_d = R_IDLE;
            default: state_d = R_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= R_IDLE;
            cnt_q   <= '0;
            r_q     <= 1'b0;
            g_q     <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == R_READ && state_d == R_READ)
                cnt_q <= cnt_q + 1'b1;
            else
                cnt_q <= '0;
            // Select the slot holding the newest completed item: the
            // one behind the writer's pointer.
            if (state_q == R_SEL)
                r_q <= ~w_ptr;
            if (state_q == R_GUARD)
                g_q <= 1'b1;
            else if (state_q == R_DONE)
                g_q <= 1'b0;
        end
    end

    always_comb begin
        capture  = 1'b0;
        rd_valid = 1'b0;
        unique case (state_q)
            R_IDLE, R_SEL, R_GUARD: ;
            R_READ:  capture  = (cnt_q == LAST);
            R_DONE:  rd_valid = 1'b1;
            default: ;
        endcase
    end

    assign r_ptr = r_q;
    assign guard = g_q;

endmodule

// File: rtl/msg_buf2_slots.sv
module msg_buf2_slots #(
    parameter int DATA_W = 16,
    parameter int NSLOT  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic              capture,
    input  logic              ridx,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] slot_q [NSLOT];
    logic [DATA_W-1:0] rd_q;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q[s] <= '0;
            else if (we && (widx == 1'(s)))
                slot_q[s] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_q <= '0;
        else if (capture)
            rd_q <= slot_q[ridx];
    end

    assign rdata = rd_q;

endmodule

// File: rtl/msg_buf2.sv
module msg_buf2 #(
    parameter int DATA_W = 16,
    parameter int WR_CYC = 3,
    parameter int RD_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_done,
    output logic              wr_stall,
    input  logic              rd_req,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    localparam int NSLOT = 2;

    logic w_ptr;
    logic r_ptr;
    logic guard;
    logic slot_we;
    logic wr_active;
    logic capture;

    msg_buf2_wr_fsm #(.WR_CYC(WR_CYC)) u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_req    (wr_req),
        .r_ptr     (r_ptr),
        .guard     (guard),
        .w_ptr     (w_ptr),
        .slot_we   (slot_we),
        .wr_active (wr_active),
        .wr_done   (wr_done),
        .wr_stall  (wr_stall)
    );

    msg_buf2_rd_fsm #(.RD_CYC(RD_CYC)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_req   (rd_req),
        .w_ptr    (w_ptr),
        .r_ptr    (r_ptr),
        .guard    (guard),
        .capture  (capture),
        .rd_valid (rd_valid)
    );

    msg_buf2_slots #(.DATA_W(DATA_W), .NSLOT(NSLOT)) u_slots (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (slot_we),
        .widx    (w_ptr),
        .wdata   (wr_data),
        .capture (capture),
        .ridx    (r_ptr),
        .rdata   (rd_data)
    );

endmodule

// File: rtl/msg_buf2_chk.sv
module msg_buf2_chk (
    input logic clk,
    input logic rst_n,
    input logic w_ptr,
    input logic r_ptr,
    input logic guard,
    input logic wr_active,
    input logic wr_done,
    input logic wr_stall,
    input logic rd_valid
);
    // R8: an active write and an active read are always on different slots
    a_r8_no_shared_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_active && guard) |-> (w_ptr != r_ptr));

    // R5: no write phase begins right after an edge with the guard high
    a_r5_guard_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_active) |-> !$past(guard));

    // R4: a write phase begins only after the pointers differed
    a_r4_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_active) |-> $past(w_ptr != r_ptr));

    // R2: the read result is a single-cycle pulse
    a_r2_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R6: the write completion is a single-cycle pulse
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> !wr_done);

    // R9: stall and completion never coincide
    a_r9_stall_not_done: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stall |-> !wr_done);

endmodule

bind msg_buf2 msg_buf2_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .w_ptr     (w_ptr),
    .r_ptr     (r_ptr),
    .guard     (guard),
    .wr_active (wr_active),
    .wr_done   (wr_done),
    .wr_stall  (wr_stall),
    .rd_valid  (rd_valid)
);

// File: tb/msg_buf2_tb.sv
`timescale 1ns/1ps
module msg_buf2_tb;
    localparam int DW = 16;
    localparam int WRC = 3;
    localparam int RDC = 4;
    localparam int RD_LAT = RDC + 3;
    localparam int WR_LAT = WRC + 1;
    localparam int NRAND = 30;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_req = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic rd_req = 1'b0;
    logic wr_done, wr_stall, rd_valid;
    logic [DW-1:0] rd_data;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] wvals [64];
    int nreq = 0;
    int last_idx = -1;
    bit wr_finished = 1'b0;

    always #2.5 clk = ~clk;

    msg_buf2 #(.DATA_W(DW), .WR_CYC(WRC), .RD_CYC(RDC)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_data(wr_data),
        .wr_done(wr_done), .wr_stall(wr_stall), .rd_req(rd_req),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    function automatic logic [DW-1:0] item_val(int i);
        return DW'(16'h4000 + i * 97);
    endfunction

    function automatic int idx_of(logic [DW-1:0] v);
        if (v == '0) return -1;
        for (int i = 0; i < nreq; i++)
            if (wvals[i] == v) return i;
        return -2;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_write(output int lat, output bit stalled);
        @(negedge clk);
        wvals[nreq] = item_val(nreq);
        wr_data = wvals[nreq];
        nreq++;
        wr_req = 1'b1;
        lat = 0;
        stalled = 1'b0;
        do begin
            @(negedge clk);
            lat++;
            if (wr_stall) stalled = 1'b1;
        end while (!wr_done && lat < 5000);
        wr_req = 1'b0;
    endtask

    task automatic do_read(output logic [DW-1:0] v, output int lat);
        @(negedge clk);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        lat = 1;
        while (!rd_valid && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        v = rd_data;
    endtask

    // Check the order of a returned item against the previous read (R7)
    // and against loss of items (R4).
    task automatic seq_check(logic [DW-1:0] v);
        int ix;
        ix = idx_of(v);
        check(ix != -2, "R7 known item", ix, last_idx);
        check(ix >= last_idx, "R7 order", ix, last_idx);
        check(ix <= last_idx + 1, "R4 no lost item", ix, last_idx + 1);
        if (ix > last_idx) last_idx = ix;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int lat;
        int kv;
        int kd;
        bit st;
        logic [DW-1:0] v;
        logic [DW-1:0] rv;
        void'($urandom(32'd1234));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: outputs quiet after reset
        check(!wr_done && !wr_stall && !rd_valid, "R1 reset outputs",
              {wr_done, wr_stall, rd_valid}, 0);

        // R1, R2: read before any write returns zero at fixed latency
        do_read(v, lat);
        check(v == '0, "R1 initial read", v, 0);
        check(lat == RD_LAT, "R2 read latency", lat, RD_LAT);

        // R1, R6: first write not held, fixed completion time
        do_write(lat, st);
        check(!st, "R1 first write not stalled", st, 0);
        check(lat == WR_LAT, "R6 write latency", lat, WR_LAT);

        // R4, R9: second write held off until a read picks up item 0
        @(negedge clk);
        wvals[nreq] = item_val(nreq);
        wr_data = wvals[nreq];
        nreq++;
        wr_req = 1'b1;
        st = 1'b1;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (!wr_stall || wr_done) st = 1'b0;
        end
        check(st, "R9 stall held while blocked", st, 1);
        rd_req = 1'b1;
        kd = 0;
        kv = 0;
        rv = '0;
        for (int k = 1; k < 40 && (kd == 0 || kv == 0); k++) begin
            @(negedge clk);
            rd_req = 1'b0;
            if (wr_done && kd == 0) begin
                kd = k;
                wr_req = 1'b0;
            end
            if (rd_valid && kv == 0) begin
                kv = k;
                rv = rd_data;
            end
        end
        check(kd != 0, "R4 held write completes after read", kd, 1);
        check(rv == wvals[0], "R3 read returns item 0", rv, wvals[0]);
        check(kv == RD_LAT, "R2 latency with writer active", kv, RD_LAT);
        last_idx = 0;

        // R3: newest item, then re-read of the same item
        do_read(v, lat);
        check(v == wvals[1], "R3 newest item", v, wvals[1]);
        do_read(v, lat);
        check(v == wvals[1], "R3 re-read same item", v, wvals[1]);
        last_idx = 1;

        // R5: write requested during the read phase waits for the guard
        @(negedge clk);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        wvals[nreq] = item_val(nreq);
        wr_data = wvals[nreq];
        nreq++;
        wr_req = 1'b1;
        kd = 0;
        kv = 0;
        st = 1'b0;
        for (int k = 4; k < 60 && kd == 0; k++) begin
            @(negedge clk);
            if (k == 4) st = wr_stall;
            if (rd_valid) begin
                kv = k;
                rv = rd_data;
            end
            if (wr_done) begin
                kd = k;
                wr_req = 1'b0;
            end
        end
        check(st, "R5 stall during read", st, 1);
        check(kv == RD_LAT, "R2 read latency under guard", kv, RD_LAT);
        check(kd == RD_LAT + 1 + WR_LAT, "R5 write starts after guard",
              kd, RD_LAT + 1 + WR_LAT);
        check(rv == wvals[1], "R3 value during guarded read", rv, wvals[1]);

        // Random concurrent traffic: R2, R4, R7
        fork
            begin
                for (int n = 0; n < NRAND; n++) begin
                    repeat ($urandom_range(0, 6)) @(negedge clk);
                    do_write(lat, st);
                end
                wr_finished = 1'b1;
            end
            begin
                int lt;
                logic [DW-1:0] rd_v;
                while (!wr_finished) begin
                    repeat ($urandom_range(0, 9)) @(negedge clk);
                    do_read(rd_v, lt);
                    check(lt == RD_LAT, "R2 random read latency", lt, RD_LAT);
                    seq_check(rd_v);
                end
            end
        join

        // R3, R4: with the writer finished, every item has been delivered
        repeat (2) @(negedge clk);
        do_read(v, lat);
        seq_check(v);
        check(v == wvals[nreq-1], "R3 final newest item", v, wvals[nreq-1]);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule